// File: doc/BRIEF.md
# Interval Timer Count Latch and Read-Back Path

This block is the read side of a three-channel, 16-bit interval timer. It sits on a byte-wide port bus with a two-bit address, a write strobe and a read strobe. Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2. Offset 3 is the control port. Each channel has a small free-running down counter that steps once per pulse on its own tick input, so the block carries live count values for its latches to capture.

Software writes the control port for one of three things. It can freeze one channel's count. It can set a channel's byte format and mode. It can issue a read-back command that captures the count, the status, or both for any group of channels. The data ports then return the captured bytes in a fixed order: status first, then the count in the channel's byte format. A captured count stays frozen until it has been fully read, even when accesses to other channels come between its bytes. When nothing is captured, a data port returns the live count.

The read data output is combinational from the address and the current state. A read strobe consumes the presented byte at the next rising clock edge.

Top module: `itl_latch_readback`

## Requirements
- R1: A write to offset 3 whose bits 7:6 hold 00, 01 or 10 addresses channel 0, 1 or 2. If bits 5:4 are 00, it is a count-latch command for that channel. Otherwise it is a programming write: the format is taken from bits 5:4, the mode from bits 3:1 and the BCD flag from bit 0. A programming write drops the channel's pending count and status captures, restarts its byte order at the low byte, and sets its null-count flag.
- R2: Each counter comes out of reset at 0xFFFF. It decrements by one, wrapping, on every clock edge where its tick bit is high. A capture records the count held before the edge at which the command is written, even if a tick arrives in the same cycle.
- R3: The format codes are 01 (low byte only), 10 (high byte only) and 11 (low byte, then high byte). Every channel resets to 11. With nothing captured, a data port returns the live count in that format. In format 11, successive reads alternate between the low and high bytes, starting with the low byte.
- R4: A captured count is read in the channel's format. Format 11 needs two reads and the others need one. The capture is released after its last byte. Its value does not change while it is pending, whatever ticks, reads or writes touch other channels.
- R5: A count-latch request for a channel whose captured count is still pending is ignored, whether it arrives as a latch command or inside a read-back command.
- R6: A write to offset 3 with bits 7:6 equal to 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low captures the count of each selected channel, and bit 4 low captures its status. If bit 0 is 1, the whole command is ignored.
- R7: The status byte is, from bit 7 down: output level (count bit 15), null-count flag, format (2 bits), mode (3 bits), BCD flag. The null-count flag is cleared by the channel's first tick after the programming write. When status and count are both pending, the status byte is returned first, then the count bytes.
- R8: A status capture for a channel whose status byte is still pending is ignored. The first captured byte is the one returned.
- R9: A read of offset 3 returns 0x00. Writes to offsets 0 to 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Port offset: 0 to 2 are data ports, 3 is the control port |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; consumes the presented byte at the next edge |
| tick | input | 3 | Per-channel decrement enable |
| rdata | output | 8 | Byte presented for the addressed port |

## Verification
A control write and a counter tick can land in the same cycle. The bench provokes this directly: it issues a latch command, a read-back command and a programming write in the same cycle as a tick on the targeted channel. The captured count must be the value before the decrement, and a programming write must leave the null-count flag set despite the tick. A long stretch of random addresses, strobes, data and tick patterns then produces many more such collisions. Every one of them is judged by a behavioural reference model that is compared against the read data in every cycle.

// File: rtl/itl_pkg.sv
package itl_pkg;

    localparam int NCH      = 3;
    localparam int CW       = 16;
    localparam int BW       = 8;
    localparam int AW       = 2;
    localparam logic [AW-1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_WORD = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [2:0] mode;
        logic       bcd;
    } cfg_t;

    typedef struct packed {
        logic       out;
        logic       nul;
        fmt_e       fmt;
        logic [2:0] mode;
        logic       bcd;
    } sts_t;

    localparam cfg_t CFG_RESET = '{fmt: FMT_WORD, mode: 3'd0, bcd: 1'b0};

    function automatic logic [BW-1:0] pick_byte(input logic [CW-1:0] w,
                                                 input fmt_e f,
                                                 input logic hi);
        case (f)
            FMT_LO:  pick_byte = w[BW-1:0];
            FMT_HI:  pick_byte = w[CW-1:BW];
            default: pick_byte = hi ? w[CW-1:BW] : w[BW-1:0];
        endcase
    endfunction

endpackage

// File: rtl/itl_ctl_decode.sv
module itl_ctl_decode
    import itl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic [BW-1:0]   wdata,
    input  logic            wr,
    output logic [NCH-1:0]  lat_cnt,
    output logic [NCH-1:0]  lat_sts,
    output logic [NCH-1:0]  prog,
    output cfg_t            cfg
);

    logic [1:0] sel;
    logic       ctl_wr;

    assign sel    = wdata[7:6];
    assign ctl_wr = wr && (addr == CTL_ADDR);

    always_comb begin
        lat_cnt = '0;
        lat_sts = '0;
        prog    = '0;
        cfg     = '{fmt: fmt_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};
        if (ctl_wr) begin
            if (sel != 2'b11) begin
                for (int i = 0; i < NCH; i++) begin
                    if (sel == 2'(i)) begin
                        if (wdata[5:4] == 2'b00) lat_cnt[i] = 1'b1;
                        else                     prog[i]    = 1'b1;
                    end
                end
            end else if (!wdata[0]) begin
                for (int i = 0; i < NCH; i++) begin
                    if (wdata[1+i]) begin
                        lat_cnt[i] = !wdata[5];
                        lat_sts[i] = !wdata[4];
                    end
                end
            end
        end
    end

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(prog)); // R1
    AST_PROG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (|prog) |-> !(|lat_cnt) && !(|lat_sts)); // R1
    AST_PROG_FMT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (|prog) |-> cfg.fmt != FMT_NONE); // R3

endmodule

// File: rtl/itl_down_counter.sv
module itl_down_counter
    import itl_pkg::*;
#(
    parameter logic [CW-1:0] RST_VAL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= RST_VAL;
        else if (tick) cnt <= cnt - 1'b1;
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == $past(cnt) - CW'(1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R2

endmodule

// File: rtl/itl_chan_readout.sv
module itl_chan_readout
    import itl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          tick,
    input  logic          prog,
    input  cfg_t          cfg,
    input  logic          lat_cnt,
    input  logic          lat_sts,
    input  logic          rd_sel,
    output logic [BW-1:0] rbyte
);

    cfg_t          cfg_q;
    logic          nul_q;
    logic          cl_v;
    logic          cl_hi;
    logic [CW-1:0] cl_val;
    logic          st_v;
    sts_t          st_val;
    logic          live_hi;
    sts_t          st_now;
    logic          two_byte;

    assign two_byte = (cfg_q.fmt == FMT_WORD);
    assign st_now   = '{out: cnt[CW-1], nul: nul_q, fmt: cfg_q.fmt,
                        mode: cfg_q.mode, bcd: cfg_q.bcd};

    always_comb begin
        if (st_v)      rbyte = st_val;
        else if (cl_v) rbyte = pick_byte(cl_val, cfg_q.fmt, cl_hi);
        else           rbyte = pick_byte(cnt, cfg_q.fmt, live_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            nul_q   <= 1'b0;
            cl_v    <= 1'b0;
            cl_hi   <= 1'b0;
            cl_val  <= '0;
            st_v    <= 1'b0;
            st_val  <= '0;
            live_hi <= 1'b0;
        end else if (prog) begin
            cfg_q   <= cfg;
            nul_q   <= 1'b1;
            cl_v    <= 1'b0;
            cl_hi   <= 1'b0;
            st_v    <= 1'b0;
            live_hi <= 1'b0;
        end else begin
            if (tick) nul_q <= 1'b0;
            if (rd_sel) begin
                if (st_v) begin
                    st_v <= 1'b0;
                end else if (cl_v) begin
                    if (two_byte && !cl_hi) begin
                        cl_hi <= 1'b1;
                    end else begin
                        cl_v  <= 1'b0;
                        cl_hi <= 1'b0;
                    end
                end else if (two_byte) begin
                    live_hi <= !live_hi;
                end
            end
            if (lat_cnt && !cl_v) begin
                cl_v   <= 1'b1;
                cl_val <= cnt;
                cl_hi  <= 1'b0;
            end
            if (lat_sts && !st_v) begin
                st_v   <= 1'b1;
                st_val <= st_now;
            end
        end
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cl_v && !prog && !rd_sel |=> cl_v && $stable(cl_val)); // R4
    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(cl_v) |-> cl_val == $past(cnt)); // R2
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        st_v && !prog && !rd_sel |=> st_v && $stable(st_val)); // R8
    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_v) |-> st_val.out == $past(cnt[CW-1])); // R7
    AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cfg_q.fmt != FMT_NONE); // R3

endmodule

// File: rtl/itl_latch_readback.sv
module itl_latch_readback
    import itl_pkg::*;
#(
    parameter logic [CW-1:0] CNT_RESET = 16'hFFFF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  addr,
    input  logic [BW-1:0]  wdata,
    input  logic           wr,
    input  logic           rd,
    input  logic [NCH-1:0] tick,
    output logic [BW-1:0]  rdata
);

    logic [NCH-1:0] lat_cnt;
    logic [NCH-1:0] lat_sts;
    logic [NCH-1:0] prog;
    cfg_t           cfg;
    logic [CW-1:0]  cnt   [NCH];
    logic [BW-1:0]  rbyte [NCH];

    itl_ctl_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr      (wr),
        .lat_cnt (lat_cnt),
        .lat_sts (lat_sts),
        .prog    (prog),
        .cfg     (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rd_sel;
        assign rd_sel = rd && (addr == AW'(c));

        itl_down_counter #(.RST_VAL(CNT_RESET)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .tick (tick[c]),
            .cnt  (cnt[c])
        );

        itl_chan_readout u_rdo (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt[c]),
            .tick    (tick[c]),
            .prog    (prog[c]),
            .cfg     (cfg),
            .lat_cnt (lat_cnt[c]),
            .lat_sts (lat_sts[c]),
            .rd_sel  (rd_sel),
            .rbyte   (rbyte[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(c)) rdata = rbyte[c];
        end
    end

    AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        wr && addr != CTL_ADDR |-> !(|lat_cnt) && !(|lat_sts) && !(|prog)); // R9

endmodule

// File: tb/test_itl_latch_readback.sv
module test_itl_latch_readback;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic       wr;
    logic       rd;
    logic [2:0] tick;
    logic [7:0] rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int m_cnt[3], m_fmt[3], m_mode[3], m_bcd[3], m_nul[3];
    int m_clv[3], m_clval[3], m_clhi[3], m_stv[3], m_stval[3], m_live[3];

    always #5 clk = !clk;

    itl_latch_readback i_itl_latch_readback (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr(wr), .rd(rd), .tick(tick), .rdata(rdata)
    );

    function automatic int pickb(int w, int f, int hi);
        if (f == 1) return w & 255;
        if (f == 2) return (w >> 8) & 255;
        return hi != 0 ? (w >> 8) & 255 : w & 255;
    endfunction

    function automatic int status_of(int c);
        return (((m_cnt[c] >> 15) & 1) << 7) | (m_nul[c] << 6) |
               (m_fmt[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
    endfunction

    function automatic int exp_byte(int a);
        if (a == 3) return 0;
        if (m_stv[a] != 0) return m_stval[a];
        if (m_clv[a] != 0) return pickb(m_clval[a], m_fmt[a], m_clhi[a]);
        return pickb(m_cnt[a], m_fmt[a], m_live[a]);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 16'hFFFF; m_fmt[c] = 3; m_mode[c] = 0; m_bcd[c] = 0;
            m_nul[c] = 0; m_clv[c] = 0; m_clval[c] = 0; m_clhi[c] = 0;
            m_stv[c] = 0; m_stval[c] = 0; m_live[c] = 0;
        end
    endtask

    task automatic model_step(int a, int d, int w, int r, int tk);
        for (int c = 0; c < 3; c++) begin
            int lc = 0, ls = 0, pg = 0;
            int sel = (d >> 6) & 3;
            int old_cnt = m_cnt[c];
            int old_sts = status_of(c);
            int old_clv = m_clv[c];
            int old_stv = m_stv[c];
            int tc = (tk >> c) & 1;
            if (w != 0 && a == 3) begin
                if (sel != 3) begin
                    if (sel == c) begin
                        if (((d >> 4) & 3) == 0) lc = 1; else pg = 1;
                    end
                end else if ((d & 1) == 0 && ((d >> (c + 1)) & 1) != 0) begin
                    lc = ((d >> 5) & 1) == 0;
                    ls = ((d >> 4) & 1) == 0;
                end
            end
            if (pg != 0) begin
                m_fmt[c] = (d >> 4) & 3; m_mode[c] = (d >> 1) & 7; m_bcd[c] = d & 1;
                m_nul[c] = 1; m_clv[c] = 0; m_clhi[c] = 0; m_stv[c] = 0; m_live[c] = 0;
            end else begin
                if (tc != 0) m_nul[c] = 0;
                if (r != 0 && a == c) begin
                    if (old_stv != 0) m_stv[c] = 0;
                    else if (old_clv != 0) begin
                        if (m_fmt[c] == 3 && m_clhi[c] == 0) m_clhi[c] = 1;
                        else begin m_clv[c] = 0; m_clhi[c] = 0; end
                    end else if (m_fmt[c] == 3) m_live[c] = 1 - m_live[c];
                end
                if (lc != 0 && old_clv == 0) begin
                    m_clv[c] = 1; m_clval[c] = old_cnt; m_clhi[c] = 0;
                end
                if (ls != 0 && old_stv == 0) begin
                    m_stv[c] = 1; m_stval[c] = old_sts;
                end
            end
            if (tc != 0) m_cnt[c] = (old_cnt - 1) & 16'hFFFF;
        end
    endtask

    task automatic step(int a, int d, int w, int r, int tk, string req);
        int e;
        addr = 2'(a); wdata = 8'(d); wr = 1'(w); rd = 1'(r); tick = 3'(tk);
        #1;
        e = exp_byte(a);
        vectors++;
        if (rdata !== 8'(e)) begin
            miscompares++;
            $display("FAIL %s: port %0d actual %02h expected %02h at %0t",
                     req, a, rdata, e[7:0], $time);
        end
        model_step(a, d, w, r, tk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl(int d, int tk, string req);
        step(3, d, 1, 0, tk, req);
    endtask

    task automatic rdp(int c, string req);
        step(c, 0, 0, 1, 0, req);
    endtask

    task automatic ticks(int n, int tk, string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, tk, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual run still active, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; addr = 0; wdata = 0; wr = 0; rd = 0; tick = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3 reset state: live word format, count 0xFFFF
        step(0, 0, 0, 0, 0, "R3 reset");
        step(2, 0, 0, 0, 0, "R3 reset");
        step(3, 0, 0, 1, 0, "R9 control read");

        // R2 R3: live two-byte reads alternate low/high while counting
        ticks(5, 3'b111, "R2");
        rdp(0, "R3 live low"); rdp(0, "R3 live high");
        ticks(300, 3'b001, "R2 wrap");

        // R4: latch ch0, interleave other traffic, read later
        ctl(8'h00, 0, "R1 latch");
        ticks(4, 3'b111, "R4 frozen");
        rdp(1, "R4 other port");
        ctl(8'h80, 0, "R1 latch ch2");
        rdp(0, "R4 latched low");
        rdp(2, "R4 other port");
        ticks(3, 3'b001, "R4 frozen");
        rdp(0, "R4 latched high");
        rdp(0, "R4 released");

        // R5: repeat latch ignored
        ctl(8'h40, 0, "R1 latch ch1");
        ticks(2, 3'b010, "R5");
        ctl(8'h40, 0, "R5 repeat latch");
        ctl(8'hC4 | 8'h10, 0, "R5 repeat via readback");
        rdp(1, "R5 old low"); rdp(1, "R5 old high"); rdp(1, "R5 live after");

        // R1 R3: formats
        ctl(8'h96, 0, "R1 program ch2 low-only");
        rdp(2, "R3 low only"); rdp(2, "R3 low only");
        ctl(8'h80, 3'b100, "R2 latch with tick");
        ticks(2, 3'b100, "R4");
        rdp(2, "R4 single byte"); rdp(2, "R3 live after");
        ctl(8'hA5, 3'b100, "R7 program with tick");
        rdp(2, "R3 high only");
        ctl(8'hB0, 0, "R1 program word");

        // R6 R7: read-back count and status ch0/ch2, status first
        ctl(8'hCA, 3'b101, "R6 readback with tick");
        rdp(0, "R7 status first"); rdp(0, "R6 count low"); rdp(0, "R6 count high");
        rdp(2, "R7 status first"); rdp(2, "R6 count low"); rdp(2, "R6 count high");
        rdp(2, "R3 live after");

        // R8: second status latch ignored (null flag changes between)
        ctl(8'h7A, 0, "R1 program ch1");
        ctl(8'hE4, 0, "R6 status ch1");
        ticks(1, 3'b010, "R7 null clear");
        ctl(8'hE4, 0, "R8 repeat status");
        rdp(1, "R8 first status kept");
        rdp(1, "R8 then live");

        // R6: reserved bit set ignores command
        ctl(8'hC3, 0, "R6 reserved bit");
        rdp(0, "R6 ignored");
        rdp(0, "R6 ignored");

        // R9: data-port writes change nothing
        step(0, 8'h00, 1, 0, 0, "R9 data write");
        step(1, 8'h95, 1, 0, 0, "R9 data write");
        rdp(1, "R9 unchanged");

        // random mix, many same-cycle control writes and ticks
        for (int i = 0; i < 4000; i++) begin
            int a = $urandom_range(0, 3);
            int r = $urandom_range(0, 1);
            int w = ($urandom_range(0, 3) == 0) ? 1 : 0;
            step(a, $urandom_range(0, 255), w, r, $urandom_range(0, 7), "R1-mix");
        end

        finish_run();
    end

endmodule